// File: doc/BRIEF.md
# Chained Debug Trigger Evaluator

This block holds ten hardware debug triggers and evaluates them every cycle against three event streams: the fetch PC, the load address and the store address (with store data). Each trigger is armed by a write that carries its compare mode, an operand select, a timing bit, an action bit, a chain bit and a 64-bit compare value. Fetch triggers are written through a port with a 2-bit slot index. The memory-side triggers are written through a second port with a 3-bit slot index.

The triggers form five fixed pairs. Pair p holds triggers 2p and 2p+1. Each pair is tied to a pair of event kinds. When a pair is chained, its two members fire only together, and only when both match in the same evaluation with equal timing bits. The unit registers a per-trigger hit vector, split into a fetch group and a memory group. It also registers a combined hit flag, two flags for the requested trap timing, and an action flag, all one cycle after the events are presented. A clear input disarms every trigger and silences the hit outputs.

Top module: `dbgtrig_unit`

## Requirements
- R1: After reset every trigger is disarmed and every hit output is 0, so no event can produce a hit until a trigger is written.
- R2: A fetch write with slot k (0..3) arms trigger 0, 1, 6 or 8 respectively. A memory write with slot k (0..5) arms trigger 2, 3, 4, 5, 7 or 9 respectively. Memory slots 6 and 7 are ignored, and a write with its valid low changes nothing.
- R3: The compare mode is unsigned against the 64-bit compare value: 0 = operand equal, 2 = operand greater than or equal, 3 = operand less than. Mode 1 never matches.
- R4: The event kinds of pairs 0..4 are (fetch, fetch), (store, store), (load, load), (fetch, store) and (fetch, load), low member first. A trigger can match only while the valid of its event kind is high.
- R5: Hits are registered: an event presented before clock edge t shows its hits after edge t. hit_fe bit k belongs to trigger 0, 1, 6, 8 for k = 0..3, and hit_be bit k belongs to trigger 2, 3, 4, 5, 7, 9 for k = 0..5.
- R6: The chain bit written with the low member (trigger 2p) chains pair p. A chained pair fires both members only when both match in the same evaluation, and otherwise fires neither. An unchained pair's members fire independently.
- R7: A chained pair whose two members have different timing bits never fires, even when both match.
- R8: With select = 1, a store trigger compares the store data instead of the address. A fetch or load trigger with select = 1 never matches.
- R9: When pair 1 (store, store) is chained, neither of its members ever fires.
- R10: hit_any is the OR of all ten hit bits. hit_now is set when a firing trigger has timing 0, hit_next when a firing trigger has timing 1, and hit_act when a firing trigger has action 1.
- R11: A clear disarms every trigger and forces all hit outputs to 0 after the same edge. A write in the same cycle as a clear is dropped.
- R12: A new write to an armed trigger replaces its whole configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Disarm all triggers and zero hits |
| fwr_vld | input | 1 | Fetch-side write valid |
| fwr_idx | input | 2 | Fetch-side slot index |
| fwr_mode | input | 2 | Compare mode for the fetch write |
| fwr_sel | input | 1 | Operand select for the fetch write |
| fwr_tim | input | 1 | Timing bit for the fetch write |
| fwr_act | input | 1 | Action bit for the fetch write |
| fwr_chain | input | 1 | Chain bit for the fetch write |
| fwr_cmp | input | TW | Compare value for the fetch write |
| mwr_vld | input | 1 | Memory-side write valid |
| mwr_idx | input | 3 | Memory-side slot index |
| mwr_mode | input | 2 | Compare mode for the memory write |
| mwr_sel | input | 1 | Operand select for the memory write |
| mwr_tim | input | 1 | Timing bit for the memory write |
| mwr_act | input | 1 | Action bit for the memory write |
| mwr_chain | input | 1 | Chain bit for the memory write |
| mwr_cmp | input | TW | Compare value for the memory write |
| fe_vld | input | 1 | Fetch event valid |
| fe_pc | input | TW | Fetch PC |
| ld_vld | input | 1 | Load event valid |
| ld_addr | input | TW | Load address |
| st_vld | input | 1 | Store event valid |
| st_addr | input | TW | Store address |
| st_data | input | TW | Store data |
| hit_fe | output | 4 | Registered fetch-trigger hits |
| hit_be | output | 6 | Registered memory-trigger hits |
| hit_any | output | 1 | OR of all hits |
| hit_now | output | 1 | A firing trigger asks for a trap before completion |
| hit_next | output | 1 | A firing trigger asks for a trap on the next instruction |
| hit_act | output | 1 | A firing trigger has its action bit set |

## Verification
A wrong stored configuration, such as a lost chain bit, a slot decoded to the wrong trigger or an arm bit that survives a clear, is invisible until an event of the right kind meets that trigger. It then shows as a wrong hit bit on the edge right after that event. The bench therefore programs each pairing and then presents events that sit exactly on, just above and just below the compare values. Because the outputs carry no memory of earlier cycles, every error appears one cycle after its cause, and the mismatch points at the trigger and pair involved.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

    localparam int NTRIG = 10;
    localparam int NPAIR = NTRIG / 2;
    localparam int NFE   = 4;
    localparam int NBE   = NTRIG - NFE;

    typedef enum logic [1:0] {
        EV_FETCH = 2'd0,
        EV_LOAD  = 2'd1,
        EV_STORE = 2'd2
    } ev_e;

    typedef enum logic [1:0] {
        MD_EQ   = 2'd0,
        MD_NONE = 2'd1,
        MD_GE   = 2'd2,
        MD_LT   = 2'd3
    } mode_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       sel;
        logic       tim;
        logic       act;
    } tcfg_t;

    // event kind watched by trigger t (low member first in each pair)
    function automatic ev_e ev_of(input int t);
        ev_e k;
        case (t / 2)
            0:       k = EV_FETCH;
            1:       k = EV_STORE;
            2:       k = EV_LOAD;
            3:       k = (t % 2 == 0) ? EV_FETCH : EV_STORE;
            default: k = (t % 2 == 0) ? EV_FETCH : EV_LOAD;
        endcase
        return k;
    endfunction

    // fetch-side slot of trigger t, or -1
    function automatic int fe_pos(input int t);
        int n;
        n = 0;
        for (int i = 0; i < t; i++) begin
            if (ev_of(i) == EV_FETCH) n++;
        end
        return (ev_of(t) == EV_FETCH) ? n : -1;
    endfunction

    // memory-side slot of trigger t, or -1
    function automatic int be_pos(input int t);
        int n;
        n = 0;
        for (int i = 0; i < t; i++) begin
            if (ev_of(i) != EV_FETCH) n++;
        end
        return (ev_of(t) != EV_FETCH) ? n : -1;
    endfunction

    // trigger held in fetch slot k
    function automatic int fe_trig(input int k);
        int r;
        r = 0;
        for (int t = 0; t < NTRIG; t++) begin
            if (fe_pos(t) == k) r = t;
        end
        return r;
    endfunction

    // trigger held in memory slot k
    function automatic int be_trig(input int k);
        int r;
        r = 0;
        for (int t = 0; t < NTRIG; t++) begin
            if (be_pos(t) == k) r = t;
        end
        return r;
    endfunction

endpackage

// File: rtl/dbgtrig_regs.sv
module dbgtrig_regs
    import dbgtrig_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       fwr_vld,
    input  logic [1:0]                 fwr_idx,
    input  tcfg_t                      fwr_cfg,
    input  logic                       fwr_chain,
    input  logic [TW-1:0]              fwr_cmp,
    input  logic                       mwr_vld,
    input  logic [2:0]                 mwr_idx,
    input  tcfg_t                      mwr_cfg,
    input  logic                       mwr_chain,
    input  logic [TW-1:0]              mwr_cmp,
    output logic [NTRIG-1:0]           armed_o,
    output tcfg_t [NTRIG-1:0]          cfg_o,
    output logic [NTRIG-1:0][TW-1:0]   cmp_o,
    output logic [NPAIR-1:0]           chain_o
);

    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        localparam int FP = fe_pos(t);
        localparam int BP = be_pos(t);

        logic          we;
        tcfg_t         wcfg;
        logic          wchain;
        logic [TW-1:0] wcmp;
        logic          armed_q;
        tcfg_t         cfg_q;
        logic [TW-1:0] cmp_q;

        if (FP >= 0) begin : g_fe
            assign we     = fwr_vld && (fwr_idx == 2'(FP));
            assign wcfg   = fwr_cfg;
            assign wchain = fwr_chain;
            assign wcmp   = fwr_cmp;
        end else begin : g_be
            assign we     = mwr_vld && (mwr_idx == 3'(BP));
            assign wcfg   = mwr_cfg;
            assign wchain = mwr_chain;
            assign wcmp   = mwr_cmp;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed_q <= 1'b0;
                cfg_q   <= '0;
                cmp_q   <= '0;
            end else if (clr) begin
                armed_q <= 1'b0;
            end else if (we) begin
                armed_q <= 1'b1;
                cfg_q   <= wcfg;
                cmp_q   <= wcmp;
            end
        end

        assign armed_o[t] = armed_q;
        assign cfg_o[t]   = cfg_q;
        assign cmp_o[t]   = cmp_q;

        if (t % 2 == 0) begin : g_chain
            logic chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= 1'b0;
                end else if (!clr && we) begin
                    chain_q <= wchain;
                end
            end
            assign chain_o[t/2] = chain_q;
        end else begin : g_nochain
            logic unused_chain;
            assign unused_chain = wchain;
        end
    end

endmodule

// File: rtl/dbgtrig_cmp.sv
module dbgtrig_cmp
    import dbgtrig_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic          armed,
    input  logic          ev_vld,
    input  logic          blocked,
    input  logic [1:0]    mode,
    input  logic [TW-1:0] operand,
    input  logic [TW-1:0] cmp,
    output logic          hit
);

    logic rel;

    always_comb begin
        unique case (mode_e'(mode))
            MD_EQ:   rel = (operand == cmp);
            MD_GE:   rel = (operand >= cmp);
            MD_LT:   rel = (operand <  cmp);
            default: rel = 1'b0;
        endcase
        hit = armed && ev_vld && !blocked && rel;
    end

endmodule

// File: rtl/dbgtrig_pair.sv
module dbgtrig_pair #(
    parameter bit NEVER_CHAIN = 1'b0
) (
    input  logic m_lo,
    input  logic m_hi,
    input  logic t_lo,
    input  logic t_hi,
    input  logic chain,
    output logic f_lo,
    output logic f_hi
);

    logic joint;

    always_comb begin
        joint = m_lo && m_hi && (t_lo == t_hi) && !NEVER_CHAIN;
        if (chain) begin
            f_lo = joint;
            f_hi = joint;
        end else begin
            f_lo = m_lo;
            f_hi = m_hi;
        end
    end

endmodule

// File: rtl/dbgtrig_unit.sv
module dbgtrig_unit
    import dbgtrig_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          fwr_vld,
    input  logic [1:0]    fwr_idx,
    input  logic [1:0]    fwr_mode,
    input  logic          fwr_sel,
    input  logic          fwr_tim,
    input  logic          fwr_act,
    input  logic          fwr_chain,
    input  logic [TW-1:0] fwr_cmp,
    input  logic          mwr_vld,
    input  logic [2:0]    mwr_idx,
    input  logic [1:0]    mwr_mode,
    input  logic          mwr_sel,
    input  logic          mwr_tim,
    input  logic          mwr_act,
    input  logic          mwr_chain,
    input  logic [TW-1:0] mwr_cmp,
    input  logic          fe_vld,
    input  logic [TW-1:0] fe_pc,
    input  logic          ld_vld,
    input  logic [TW-1:0] ld_addr,
    input  logic          st_vld,
    input  logic [TW-1:0] st_addr,
    input  logic [TW-1:0] st_data,
    output logic [NFE-1:0] hit_fe,
    output logic [NBE-1:0] hit_be,
    output logic          hit_any,
    output logic          hit_now,
    output logic          hit_next,
    output logic          hit_act
);

    logic [NTRIG-1:0]         armed;
    tcfg_t [NTRIG-1:0]        cfg;
    logic [NTRIG-1:0][TW-1:0] cmp;
    logic [NPAIR-1:0]         chain;
    logic [NTRIG-1:0]         match;
    logic [NTRIG-1:0]         fire;
    logic [NTRIG-1:0]         tim_v;
    logic [NTRIG-1:0]         act_v;

    dbgtrig_regs #(.TW(TW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .fwr_vld   (fwr_vld),
        .fwr_idx   (fwr_idx),
        .fwr_cfg   ('{mode: fwr_mode, sel: fwr_sel, tim: fwr_tim, act: fwr_act}),
        .fwr_chain (fwr_chain),
        .fwr_cmp   (fwr_cmp),
        .mwr_vld   (mwr_vld),
        .mwr_idx   (mwr_idx),
        .mwr_cfg   ('{mode: mwr_mode, sel: mwr_sel, tim: mwr_tim, act: mwr_act}),
        .mwr_chain (mwr_chain),
        .mwr_cmp   (mwr_cmp),
        .armed_o   (armed),
        .cfg_o     (cfg),
        .cmp_o     (cmp),
        .chain_o   (chain)
    );

    // one comparator per trigger, event source picked by its pair binding
    for (genvar t = 0; t < NTRIG; t++) begin : g_cmp
        localparam ev_e KIND = ev_of(t);
        logic          vld;
        logic          blk;
        logic [TW-1:0] opnd;

        if (KIND == EV_FETCH) begin : g_f
            assign vld  = fe_vld;
            assign blk  = cfg[t].sel;
            assign opnd = fe_pc;
        end else if (KIND == EV_LOAD) begin : g_l
            assign vld  = ld_vld;
            assign blk  = cfg[t].sel;
            assign opnd = ld_addr;
        end else begin : g_s
            assign vld  = st_vld;
            assign blk  = 1'b0;
            assign opnd = cfg[t].sel ? st_data : st_addr;
        end

        dbgtrig_cmp #(.TW(TW)) u_cmp (
            .armed   (armed[t]),
            .ev_vld  (vld),
            .blocked (blk),
            .mode    (cfg[t].mode),
            .operand (opnd),
            .cmp     (cmp[t]),
            .hit     (match[t])
        );

        assign tim_v[t] = cfg[t].tim;
        assign act_v[t] = cfg[t].act;
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam bit SS = (ev_of(2*p) == EV_STORE) && (ev_of(2*p+1) == EV_STORE);
        dbgtrig_pair #(.NEVER_CHAIN(SS)) u_pair (
            .m_lo  (match[2*p]),
            .m_hi  (match[2*p+1]),
            .t_lo  (tim_v[2*p]),
            .t_hi  (tim_v[2*p+1]),
            .chain (chain[p]),
            .f_lo  (fire[2*p]),
            .f_hi  (fire[2*p+1])
        );
    end

    logic [NFE-1:0] fe_d;
    logic [NBE-1:0] be_d;

    for (genvar k = 0; k < NFE; k++) begin : g_feo
        assign fe_d[k] = fire[fe_trig(k)];
    end
    for (genvar k = 0; k < NBE; k++) begin : g_beo
        assign be_d[k] = fire[be_trig(k)];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hit_fe   <= '0;
            hit_be   <= '0;
            hit_any  <= 1'b0;
            hit_now  <= 1'b0;
            hit_next <= 1'b0;
            hit_act  <= 1'b0;
        end else begin
            hit_fe   <= fe_d;
            hit_be   <= be_d;
            hit_any  <= |fire;
            hit_now  <= |(fire & ~tim_v);
            hit_next <= |(fire & tim_v);
            hit_act  <= |(fire & act_v);
        end
    end

endmodule

// File: rtl/dbgtrig_chk.sv
module dbgtrig_chk #(
    parameter int TW = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       fwr_vld,
    input logic       mwr_vld,
    input logic       fe_vld,
    input logic       ld_vld,
    input logic       st_vld,
    input logic [3:0] hit_fe,
    input logic [5:0] hit_be,
    input logic       hit_any,
    input logic       hit_now,
    input logic       hit_next,
    input logic       hit_act
);

    AST_CLR_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!hit_any && hit_fe == 4'd0 && hit_be == 6'd0)); // R11

    AST_CLR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        clr ##1 (!fwr_vld && !mwr_vld && !clr) |=> !hit_any); // R11

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fe_vld && !ld_vld && !st_vld) |=> !hit_any); // R4

    AST_FE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_vld |=> (hit_fe == 4'd0)); // R4

    AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_vld && !st_vld) |=> (hit_be == 6'd0)); // R4

    AST_HIT_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (hit_now || hit_next)); // R10

    AST_ACT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_act |-> hit_any); // R10

endmodule

bind dbgtrig_unit dbgtrig_chk #(.TW(TW)) u_chk (.*);

// File: tb/sim_dbgtrig_unit.sv
module sim_dbgtrig_unit;
    localparam int TW = 64;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic fwr_vld = 0, fwr_sel = 0, fwr_tim = 0, fwr_act = 0, fwr_chain = 0;
    logic [1:0] fwr_idx = 0, fwr_mode = 0;
    logic [TW-1:0] fwr_cmp = 0;
    logic mwr_vld = 0, mwr_sel = 0, mwr_tim = 0, mwr_act = 0, mwr_chain = 0;
    logic [2:0] mwr_idx = 0;
    logic [1:0] mwr_mode = 0;
    logic [TW-1:0] mwr_cmp = 0;
    logic fe_vld = 0, ld_vld = 0, st_vld = 0;
    logic [TW-1:0] fe_pc = 0, ld_addr = 0, st_addr = 0, st_data = 0;
    logic [3:0] hit_fe;
    logic [5:0] hit_be;
    logic hit_any, hit_now, hit_next, hit_act;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model of the trigger state
    bit        m_en [10];
    bit [1:0]  m_md [10];
    bit        m_sel[10];
    bit        m_tim[10];
    bit        m_act[10];
    bit [63:0] m_cmp[10];
    bit        m_ch [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgtrig_unit #(.TW(TW)) u0 (.*);

    // 0 fetch, 1 load, 2 store
    function automatic int kind(int t);
        case (t)
            0, 1, 6, 8: return 0;
            4, 5, 9:    return 1;
            default:    return 2;
        endcase
    endfunction

    function automatic int fslot(int k);
        case (k) 0: return 0; 1: return 1; 2: return 6; default: return 8; endcase
    endfunction

    function automatic int mslot(int k);
        case (k) 0: return 2; 1: return 3; 2: return 4; 3: return 5; 4: return 7; default: return 9; endcase
    endfunction

    function automatic bit mmatch(int t);
        bit v;
        bit [63:0] op;
        int k;
        k = kind(t);
        v = (k == 0) ? fe_vld : (k == 1) ? ld_vld : st_vld;
        op = (k == 0) ? fe_pc : (k == 1) ? ld_addr : st_addr;
        if (!m_en[t] || !v) return 0;
        if (m_sel[t]) begin
            if (k != 2) return 0;
            op = st_data;
        end
        case (m_md[t])
            2'd0: return op == m_cmp[t];
            2'd2: return op >= m_cmp[t];
            2'd3: return op < m_cmp[t];
            default: return 0;
        endcase
    endfunction

    // {hit_fe, hit_be, any, now, next, act}
    function automatic bit [13:0] expect_out();
        bit m[10];
        bit f[10];
        bit [13:0] r;
        bit any, nw, nx, ac;
        for (int t = 0; t < 10; t++) m[t] = mmatch(t);
        for (int p = 0; p < 5; p++) begin
            if (!m_ch[p]) begin
                f[2*p] = m[2*p]; f[2*p+1] = m[2*p+1];
            end else begin
                f[2*p] = m[2*p] && m[2*p+1] && (m_tim[2*p] == m_tim[2*p+1]) && (p != 1);
                f[2*p+1] = f[2*p];
            end
        end
        r = '0; any = 0; nw = 0; nx = 0; ac = 0;
        for (int k = 0; k < 4; k++) r[10+k] = f[fslot(k)];
        for (int k = 0; k < 6; k++) r[4+k] = f[mslot(k)];
        for (int t = 0; t < 10; t++) begin
            if (f[t]) begin
                any = 1;
                if (m_tim[t]) nx = 1; else nw = 1;
                if (m_act[t]) ac = 1;
            end
        end
        r[3:0] = {any, nw, nx, ac};
        return r;
    endfunction

    function automatic bit [13:0] actual_out();
        return {hit_fe, hit_be, hit_any, hit_now, hit_next, hit_act};
    endfunction

    task automatic check(string req, bit [13:0] act, bit [13:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_put(int t, bit [1:0] md, bit sel, bit tim, bit act, bit ch, bit [63:0] cv);
        m_en[t] = 1; m_md[t] = md; m_sel[t] = sel; m_tim[t] = tim; m_act[t] = act; m_cmp[t] = cv;
        if (t % 2 == 0) m_ch[t/2] = ch;
    endtask

    task automatic wr_f(int idx, bit [1:0] md, bit sel, bit tim, bit act, bit ch, bit [63:0] cv);
        @(negedge clk);
        fwr_vld = 1; fwr_idx = 2'(idx); fwr_mode = md; fwr_sel = sel;
        fwr_tim = tim; fwr_act = act; fwr_chain = ch; fwr_cmp = cv;
        @(posedge clk); #1;
        fwr_vld = 0;
        model_put(fslot(idx), md, sel, tim, act, ch, cv);
    endtask

    task automatic wr_m(int idx, bit [1:0] md, bit sel, bit tim, bit act, bit ch, bit [63:0] cv);
        @(negedge clk);
        mwr_vld = 1; mwr_idx = 3'(idx); mwr_mode = md; mwr_sel = sel;
        mwr_tim = tim; mwr_act = act; mwr_chain = ch; mwr_cmp = cv;
        @(posedge clk); #1;
        mwr_vld = 0;
        if (idx < 6) model_put(mslot(idx), md, sel, tim, act, ch, cv);
    endtask

    task automatic ev(string req, bit fv, bit [63:0] pc, bit lv, bit [63:0] la,
                      bit sv, bit [63:0] sa, bit [63:0] sd);
        bit [13:0] e;
        @(negedge clk);
        fe_vld = fv; fe_pc = pc; ld_vld = lv; ld_addr = la;
        st_vld = sv; st_addr = sa; st_data = sd;
        e = expect_out();
        @(posedge clk); #1;
        check(req, actual_out(), e);
        fe_vld = 0; ld_vld = 0; st_vld = 0;
    endtask

    task automatic do_clr(bit with_wr);
        @(negedge clk);
        clr = 1;
        if (with_wr) begin
            fwr_vld = 1; fwr_idx = 0; fwr_mode = 2'd2; fwr_sel = 0; fwr_cmp = 0; fwr_chain = 0;
        end
        @(posedge clk); #1;
        check("R11 clear zeroes hits", actual_out(), 14'd0);
        clr = 0; fwr_vld = 0;
        for (int t = 0; t < 10; t++) m_en[t] = 0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int t = 0; t < 10; t++) m_en[t] = 0;
        for (int p = 0; p < 5; p++) m_ch[p] = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", actual_out(), 14'd0);
        @(negedge clk); rst_n = 1;
        ev("R1 disarmed after reset", 1, 0, 1, 0, 1, 0, 0);

        // R3 compare modes on fetch triggers
        wr_f(0, 2'd0, 0, 0, 1, 0, 64'h1000);
        ev("R3 eq hit", 1, 64'h1000, 0, 0, 0, 0, 0);
        ev("R3 eq miss", 1, 64'h1001, 0, 0, 0, 0, 0);
        wr_f(1, 2'd2, 0, 1, 0, 0, 64'h2000);
        ev("R3 ge at bound", 1, 64'h2000, 0, 0, 0, 0, 0);
        ev("R3 ge below", 1, 64'h1fff, 0, 0, 0, 0, 0);
        wr_f(2, 2'd3, 0, 0, 0, 0, 64'h500);
        ev("R3 lt below", 1, 64'h4ff, 0, 0, 0, 0, 0);
        ev("R3 lt at bound", 1, 64'h500, 0, 0, 0, 0, 0);
        wr_f(3, 2'd1, 0, 0, 0, 0, 64'h0);
        ev("R3 mode1 never", 1, 64'h0, 0, 0, 0, 0, 0);

        // R2 slot decoding and ignored writes
        wr_m(0, 2'd0, 0, 0, 0, 0, 64'h3000);
        ev("R5 store slot0 bit", 0, 0, 0, 0, 1, 64'h3000, 0);
        wr_m(6, 2'd2, 0, 0, 0, 0, 64'h0);
        wr_m(7, 2'd2, 0, 0, 0, 0, 64'h0);
        ev("R2 slots 6 7 ignored", 0, 0, 1, 64'h77, 1, 64'h77, 0);
        @(negedge clk);
        mwr_idx = 0; mwr_mode = 2'd2; mwr_cmp = 0; mwr_vld = 0;
        @(posedge clk); #1;
        ev("R2 valid low no change", 0, 0, 0, 0, 1, 64'h3000, 0);
        wr_m(2, 2'd0, 0, 0, 0, 0, 64'h40);
        ev("R4 load needs load valid", 0, 0, 0, 64'h40, 1, 64'h40, 0);
        ev("R4 load trigger hit", 0, 0, 1, 64'h40, 0, 0, 0);

        // R12 rewrite replaces config
        wr_m(0, 2'd3, 0, 1, 1, 0, 64'h10);
        ev("R12 old compare gone", 0, 0, 0, 0, 1, 64'h3000, 0);
        ev("R12 new compare", 0, 0, 0, 0, 1, 64'h8, 0);

        // R8 select
        wr_m(1, 2'd0, 1, 0, 0, 0, 64'hdead);
        ev("R8 store data compare", 0, 0, 0, 0, 1, 64'h9999, 64'hdead);
        wr_m(3, 2'd2, 1, 0, 0, 0, 64'h0);
        ev("R8 load select never", 0, 0, 1, 64'h50, 0, 0, 0);

        do_clr(1'b0);
        ev("R11 disarmed after clear", 1, 64'h1000, 1, 64'h40, 1, 64'h8, 64'hdead);

        // R6 chaining on pair 0 (fetch, fetch)
        wr_f(0, 2'd0, 0, 0, 0, 1, 64'h100);
        wr_f(1, 2'd3, 0, 0, 0, 0, 64'h200);
        ev("R6 chained both match", 1, 64'h100, 0, 0, 0, 0, 0);
        ev("R6 chained one match", 1, 64'h150, 0, 0, 0, 0, 0);
        // R7 timing mismatch
        wr_f(1, 2'd3, 0, 1, 0, 0, 64'h200);
        ev("R7 timing differs", 1, 64'h100, 0, 0, 0, 0, 0);
        // pair 3 (fetch, store) chain
        wr_f(2, 2'd0, 0, 1, 1, 1, 64'h700);
        wr_m(4, 2'd0, 0, 1, 0, 0, 64'h800);
        ev("R6 cross pair only fetch", 1, 64'h700, 0, 0, 0, 0, 0);
        ev("R6 cross pair both", 1, 64'h700, 0, 0, 1, 64'h800, 0);
        // R9 store-store chain
        wr_m(0, 2'd2, 0, 0, 0, 1, 64'h0);
        wr_m(1, 2'd2, 0, 0, 0, 0, 64'h0);
        ev("R9 store pair chained never", 0, 0, 0, 0, 1, 64'h5, 0);
        wr_m(0, 2'd2, 0, 0, 0, 0, 64'h0);
        ev("R9 unchained store pair fires", 0, 0, 0, 0, 1, 64'h5, 0);

        do_clr(1'b1);
        ev("R11 write during clear dropped", 1, 64'h5, 0, 0, 0, 0, 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            bit [63:0] pool[4];
            pool[0] = 64'h40; pool[1] = 64'h80; pool[2] = 64'hc0; pool[3] = 64'h100;
            op = $urandom_range(0, 9);
            if (op < 2) begin
                wr_f($urandom_range(0, 3), 2'($urandom), 1'($urandom_range(0, 3) == 0),
                     1'($urandom), 1'($urandom), 1'($urandom), pool[$urandom_range(0, 3)]);
            end else if (op < 4) begin
                wr_m($urandom_range(0, 7), 2'($urandom), 1'($urandom_range(0, 3) == 0),
                     1'($urandom), 1'($urandom), 1'($urandom), pool[$urandom_range(0, 3)]);
            end else if (op == 4 && $urandom_range(0, 9) == 0) begin
                do_clr(1'($urandom));
            end else begin
                ev("R10 random evaluation", 1'($urandom), pool[$urandom_range(0, 3)],
                   1'($urandom), pool[$urandom_range(0, 3)],
                   1'($urandom), pool[$urandom_range(0, 3)], pool[$urandom_range(0, 3)]);
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule